// File: doc/BRIEF.md
# DS3 Idle Signal Generator

This block sits in a DS3 transmit path and carries one serial bit per clock. When idle is off, every input bit goes to the output unchanged. When idle is on, it replaces the whole M-frame with the standard idle signal:

- Each 84-bit payload run becomes a repeating two-ones, two-zeros pattern that starts over after every overhead bit.
- The multiframe, subframe-alignment and X overhead positions get fixed values.
- The C-bits of the third subframe are cleared.
- The two parity bits carry the payload parity of the frame this block sent before.

An internal position counter splits the 4760-bit M-frame into seven subframes of eight 85-bit blocks. Bit 0 of each block is the overhead bit. A start-of-frame strobe realigns the counter. The idle request is sampled only on the first bit of an M-frame, so a frame never comes out half idle.

Positions are numbered from the first bit of the M-frame, counting from zero. Subframe s runs from 0 to 6 and block b from 0 to 7. The overhead bit of block b in subframe s is at bit 680·s + 85·b. Each block's payload is at offsets 1 to 84.

Top module: `ds3i_idle_gen`

## Requirements
- R1: While idle is not active for the current frame, `dout` equals the `din` bit presented one clock earlier.
- R2: In an idle frame, payload offset k (1..84) of every block is 1 when (k-1) mod 4 is 0 or 1, and 0 otherwise. The pattern restarts after each overhead bit.
- R3: In an idle frame, the block-0 overhead bits of subframes 4, 5 and 6 (the multiframe bits) are output as 0, 1, 0 respectively.
- R4: In an idle frame, the overhead bits of blocks 1, 3, 5 and 7 in every subframe are output as 1, 0, 0, 1 respectively.
- R5: In an idle frame, the block-0 overhead bits of subframes 0 and 1 (the X-bits) are output as 1.
- R6: In an idle frame, the block-0 overhead bits of subframes 2 and 3 both equal the XOR of all payload bits output during the previous frame, whether or not that frame was idle. This value is 0 before any frame has completed after reset.
- R7: In an idle frame, the overhead bits of blocks 2, 4 and 6 in subframe 2 are output as 0. The same positions in every other subframe pass `din` through.
- R8: `idle_req` is sampled only on bit 0 of an M-frame and then holds for the whole frame. `idle_on` is high, aligned with `dout`, for every bit produced in idle mode.
- R9: A high `sof_in` marks the current `din` bit as bit 0 of a new M-frame, wherever the counter was.
- R10: The output lags the input by one clock. While reset is asserted (active low), `dout` and `idle_on` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one DS3 bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_in | input | 1 | Marks `din` as the first bit of an M-frame |
| din | input | 1 | Serial transmit data in |
| idle_req | input | 1 | Requests idle for frames starting while high |
| dout | output | 1 | Serial transmit data out |
| idle_on | output | 1 | High while the `dout` bit was produced in idle mode |

## Verification
The bound checker tests several rules on every clock:
- The mode never changes except after a frame-start bit.
- Output follows input when idle is off.
- Payload follows the pattern phase.
- The X-bits are forced high.
- The third-subframe C-bits are cleared, and the other C-bits pass through.

Some behaviours depend on history across a whole frame or on scenario timing. Only the bench's scenarios can show these:
- The multiframe and alignment values at their positions.
- Parity carried over from a preceding non-idle frame.
- A request raised mid-frame being deferred.
- A mid-frame realignment through `sof_in`.

// File: rtl/ds3i_pkg.sv
package ds3i_pkg;

    // Role of the bit currently at the input, decoded from its frame position
    typedef enum logic [2:0] {
        SLOT_PAY = 3'd0,
        SLOT_X   = 3'd1,
        SLOT_P   = 3'd2,
        SLOT_M   = 3'd3,
        SLOT_F   = 3'd4,
        SLOT_C   = 3'd5
    } slot_e;

    // Frame geometry defaults
    localparam int SUBFRAMES_DEF  = 7;
    localparam int BLOCKS_DEF     = 8;
    localparam int BLOCK_BITS_DEF = 85;

endpackage

// File: rtl/ds3i_frame_pos.sv
module ds3i_frame_pos #(
    parameter int SUBFRAMES  = ds3i_pkg::SUBFRAMES_DEF,
    parameter int BLOCKS     = ds3i_pkg::BLOCKS_DEF,
    parameter int BLOCK_BITS = ds3i_pkg::BLOCK_BITS_DEF,
    localparam int SFW = $clog2(SUBFRAMES),
    localparam int BKW = $clog2(BLOCKS),
    localparam int BTW = $clog2(BLOCK_BITS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sof_in,
    output logic [SFW-1:0] cur_sf,
    output logic [BKW-1:0] cur_blk,
    output logic [BTW-1:0] cur_bit,
    output logic           frm_start
);

    localparam logic [SFW-1:0] SF_LAST = SFW'(SUBFRAMES - 1);
    localparam logic [BKW-1:0] BK_LAST = BKW'(BLOCKS - 1);
    localparam logic [BTW-1:0] BT_LAST = BTW'(BLOCK_BITS - 1);

    typedef struct packed {
        logic [SFW-1:0] sf;
        logic [BKW-1:0] blk;
        logic [BTW-1:0] bt;
    } pos_t;

    pos_t pos_q, pos_d, cur;

    always_comb begin
        cur   = sof_in ? '0 : pos_q;
        pos_d = cur;
        if (cur.bt == BT_LAST) begin
            pos_d.bt = '0;
            if (cur.blk == BK_LAST) begin
                pos_d.blk = '0;
                pos_d.sf  = (cur.sf == SF_LAST) ? '0 : cur.sf + 1'b1;
            end else begin
                pos_d.blk = cur.blk + 1'b1;
            end
        end else begin
            pos_d.bt = cur.bt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign cur_sf    = cur.sf;
    assign cur_blk   = cur.blk;
    assign cur_bit   = cur.bt;
    assign frm_start = (cur == '0);

endmodule

// File: rtl/ds3i_slot_map.sv
module ds3i_slot_map #(
    parameter int SUBFRAMES  = ds3i_pkg::SUBFRAMES_DEF,
    parameter int BLOCKS     = ds3i_pkg::BLOCKS_DEF,
    parameter int BLOCK_BITS = ds3i_pkg::BLOCK_BITS_DEF,
    parameter int RUN        = 2,
    parameter int X_SUBFR    = 2,
    parameter int P_SUBFR    = 2,
    parameter int M_LEN      = 3,
    parameter logic [M_LEN-1:0] M_WORD = 3'b010,
    parameter int F_LEN      = 4,
    parameter logic [F_LEN-1:0] F_WORD = 4'b1001,
    parameter int C_ZERO_SF  = 2,
    localparam int SFW = $clog2(SUBFRAMES),
    localparam int BKW = $clog2(BLOCKS),
    localparam int BTW = $clog2(BLOCK_BITS)
) (
    input  logic [SFW-1:0]  sf,
    input  logic [BKW-1:0]  blk,
    input  logic [BTW-1:0]  bt,
    output ds3i_pkg::slot_e slot,
    output logic            fixed_val,
    output logic            c_zero,
    output logic            pat_one
);
    import ds3i_pkg::*;

    localparam int M_FIRST = X_SUBFR + P_SUBFR;
    localparam logic [BTW-1:0] PERIOD = BTW'(2 * RUN);
    localparam logic [BTW-1:0] RUN_V  = BTW'(RUN);

    logic [BTW-1:0] pay_idx;
    logic           m_val, f_val;

    always_comb begin
        pay_idx = bt - 1'b1;
        pat_one = ((pay_idx % PERIOD) < RUN_V);
    end

    // multiframe value picked by subframe, alignment value by block
    always_comb begin
        m_val = 1'b0;
        for (int i = 0; i < M_LEN; i++) begin
            if (sf == SFW'(M_FIRST + i)) m_val = M_WORD[M_LEN-1-i];
        end
        f_val = 1'b0;
        for (int i = 0; i < F_LEN; i++) begin
            if (blk == BKW'(2 * i + 1)) f_val = F_WORD[F_LEN-1-i];
        end
    end

    always_comb begin
        slot      = SLOT_PAY;
        fixed_val = 1'b0;
        c_zero    = 1'b0;
        if (bt == '0) begin
            if (blk == '0) begin
                if (sf < SFW'(X_SUBFR)) begin
                    slot      = SLOT_X;
                    fixed_val = 1'b1;
                end else if (sf < SFW'(M_FIRST)) begin
                    slot = SLOT_P;
                end else begin
                    slot      = SLOT_M;
                    fixed_val = m_val;
                end
            end else if (blk[0]) begin
                slot      = SLOT_F;
                fixed_val = f_val;
            end else begin
                slot   = SLOT_C;
                c_zero = (sf == SFW'(C_ZERO_SF));
            end
        end
    end

endmodule

// File: rtl/ds3i_parity.sv
module ds3i_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_start,
    input  logic pay_vld,
    input  logic bit_in,
    output logic par_prev
);

    typedef struct packed {
        logic acc;
        logic prev;
    } par_t;

    par_t par_q, par_d;

    always_comb begin
        par_d = par_q;
        if (frm_start) begin
            par_d.prev = par_q.acc;
            par_d.acc  = 1'b0;
        end else if (pay_vld) begin
            par_d.acc = par_q.acc ^ bit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign par_prev = par_q.prev;

endmodule

// File: rtl/ds3i_idle_gen.sv
module ds3i_idle_gen #(
    parameter int SUBFRAMES  = ds3i_pkg::SUBFRAMES_DEF,
    parameter int BLOCKS     = ds3i_pkg::BLOCKS_DEF,
    parameter int BLOCK_BITS = ds3i_pkg::BLOCK_BITS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_in,
    input  logic din,
    input  logic idle_req,
    output logic dout,
    output logic idle_on
);
    import ds3i_pkg::*;

    localparam int SFW = $clog2(SUBFRAMES);
    localparam int BKW = $clog2(BLOCKS);
    localparam int BTW = $clog2(BLOCK_BITS);

    typedef struct packed {
        logic dout;
        logic idle_on;
    } out_t;

    out_t st_q, st_d;

    logic [SFW-1:0] sf_w;
    logic [BKW-1:0] blk_w;
    logic [BTW-1:0] bit_w;
    logic           frm_start_w;
    slot_e          slot_w;
    logic           fixed_w, c_zero_w, pat_one_w, par_prev_w;
    logic           act_w, out_w;

    ds3i_frame_pos #(
        .SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .BLOCK_BITS(BLOCK_BITS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .sof_in(sof_in),
        .cur_sf(sf_w), .cur_blk(blk_w), .cur_bit(bit_w),
        .frm_start(frm_start_w)
    );

    ds3i_slot_map #(
        .SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .BLOCK_BITS(BLOCK_BITS)
    ) u_map (
        .sf(sf_w), .blk(blk_w), .bt(bit_w),
        .slot(slot_w), .fixed_val(fixed_w), .c_zero(c_zero_w), .pat_one(pat_one_w)
    );

    ds3i_parity u_par (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start_w),
        .pay_vld(slot_w == SLOT_PAY), .bit_in(out_w), .par_prev(par_prev_w)
    );

    // mode is frozen for the frame; only a frame-start bit may re-sample it
    always_comb begin
        act_w = frm_start_w ? idle_req : st_q.idle_on;
        out_w = din;
        if (act_w) begin
            unique case (slot_w)
                SLOT_PAY: out_w = pat_one_w;
                SLOT_P:   out_w = par_prev_w;
                SLOT_C:   out_w = c_zero_w ? 1'b0 : din;
                default:  out_w = fixed_w;
            endcase
        end
        st_d.dout    = out_w;
        st_d.idle_on = act_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign idle_on = st_q.idle_on;

endmodule

// File: rtl/ds3i_idle_chk.sv
module ds3i_idle_chk (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_start,
    input logic            act,
    input ds3i_pkg::slot_e slot,
    input logic            pat_one,
    input logic            c_zero,
    input logic            din,
    input logic            dout,
    input logic            idle_on
);
    import ds3i_pkg::*;

    // R8
    frame_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_start |=> $stable(idle_on));

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (dout == $past(din)));

    // R2
    payload_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && slot == SLOT_PAY) |=> (dout == $past(pat_one)));

    // R5
    xbit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && slot == SLOT_X) |=> dout);

    // R7
    cbit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && slot == SLOT_C && c_zero) |=> !dout);

    // R7
    cbit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && slot == SLOT_C && !c_zero) |=> (dout == $past(din)));

endmodule

bind ds3i_idle_gen ds3i_idle_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start_w), .act(act_w),
    .slot(slot_w), .pat_one(pat_one_w), .c_zero(c_zero_w),
    .din(din), .dout(dout), .idle_on(idle_on)
);

// File: tb/ds3i_idle_gen_test.sv
module ds3i_idle_gen_test;

    localparam int FRAME  = 4760;
    localparam int SUBLEN = 680;
    localparam int BLKLEN = 85;
    localparam int RESYNC = 3 * FRAME + 1500;
    localparam int TOTAL  = RESYNC + FRAME + 100;

    typedef struct {
        logic  d;
        logic  on;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_in = 1'b0;
    logic din = 1'b0;
    logic idle_req = 1'b0;
    logic dout, idle_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    // reference model state
    int   m_pos = 0;
    logic m_idle = 1'b0;
    logic m_acc = 1'b0;
    logic m_prev = 1'b0;
    int   m_since_sof = 0;

    always #10 clk = ~clk;

    ds3i_idle_gen uut (
        .clk(clk), .rst_n(rst_n), .sof_in(sof_in), .din(din),
        .idle_req(idle_req), .dout(dout), .idle_on(idle_on)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive one bit and push the expected output
    task automatic send_bit(input logic sof, input logic d);
        exp_t e;
        int s, b, j;
        @(negedge clk);
        sof_in = sof;
        din    = d;
        if (sof) begin
            m_pos = 0;
            m_since_sof = 0;
        end
        if (m_pos == 0) begin
            m_idle = idle_req;
            m_prev = m_acc;
            m_acc  = 1'b0;
        end
        s = m_pos / SUBLEN;
        b = (m_pos % SUBLEN) / BLKLEN;
        j = m_pos % BLKLEN;
        e.d = d;
        if (m_idle) begin
            if (j != 0)                e.d = (((j - 1) % 4) < 2);
            else if (b == 0 && s < 2)  e.d = 1'b1;
            else if (b == 0 && s < 4)  e.d = m_prev;
            else if (b == 0)           e.d = (s == 5);
            else if (b % 2 == 1)       e.d = (b == 1 || b == 7);
            else if (s == 2)           e.d = 1'b0;
        end
        if (j != 0) m_acc = m_acc ^ e.d;
        e.on = m_idle;
        if (idle_req != m_idle && m_pos != 0) e.tag = "R8";
        else if (m_since_sof < BLKLEN)        e.tag = "R9";
        else if (!m_idle)                     e.tag = "R1";
        else if (j != 0)                      e.tag = "R2";
        else if (b == 0 && s < 2)             e.tag = "R5";
        else if (b == 0 && s < 4)             e.tag = "R6";
        else if (b == 0)                      e.tag = "R3";
        else if (b % 2 == 1)                  e.tag = "R4";
        else                                  e.tag = "R7";
        sb.push_back(e);
        m_since_sof++;
        m_pos = (m_pos + 1) % FRAME;
    endtask

    // monitor: one result per clock, one register of latency (R10)
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(e.tag, dout, e.d);
                check("R8 idle_on", idle_on, e.on);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset dout", dout, 1'b0);
        check("R10 reset idle_on", idle_on, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < TOTAL; n++) begin
            if (n < 2000)                     idle_req = 1'b0;
            else if (n < 2 * FRAME + 3000)    idle_req = 1'b1;
            else if (n < RESYNC)              idle_req = 1'b0;
            else                              idle_req = 1'b1;
            send_bit((n == 0) || (n == RESYNC), 1'($urandom));
        end
        @(negedge clk);
        sof_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 queue drained", 1'(sb.size() == 0), 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule